// File: doc/BRIEF.md
# Stream lane width adapter

The adapter joins two streaming buses that carry different numbers of byte lanes of equal width. Each side has data, a per-lane keep mask, valid, ready, an end-of-frame marker (last) and a bad-frame flag (user). The flag is only meaningful together with last. When the input side has fewer lanes, the block packs several narrow beats into one wide beat. When the input side has more lanes, it splits each wide beat into several narrow beats. When both sides have the same lane count, it is a plain wire.

The ratio between the two lane counts must be a whole number, for example 2 to 6. The adapter holds at most one wide word. Wait states only ever show up on the wide side: in packing mode the wide output is invalid while it fills, and in splitting mode the wide input is not ready while it drains. A narrow beat that ends a frame closes a wide word early, and empty lanes are cleared in that word. Narrow segments with no kept lanes are skipped when splitting. Frame markers always travel with the last beat that carries data. A synchronous reset discards any word that is partly built or partly drained.

Top module: `lane_width_adapter`

## Requirements
- R1: A beat moves on either side only in a cycle where its valid and ready are both high. While outValid is high and outReady is low, outData, outKeep, outLast and outUser keep their values.
- R2: Packing (IN_LANES < OUT_LANES): successive narrow beats fill the wide word from the lowest segment up. The first beat of a word lands in output lanes 0..IN_LANES-1, with lane 0 in the least significant LANE_W bits. The wide word is valid in the cycle after the beat that completes it.
- R3: Packing: a narrow beat with inLast high closes the wide word even when the word is not full. The lanes not filled carry keep 0 and data 0, and the next beat starts a new word at segment 0.
- R4: Packing: outLast equals inLast of the beat that closed the word. outUser equals inUser of that beat when inLast is high, and is 0 otherwise.
- R5: Splitting (IN_LANES > OUT_LANES): an accepted wide beat is sent out as narrow beats, lowest segment first. The first narrow beat is valid in the cycle after the wide beat is accepted.
- R6: Splitting: a segment whose keep bits are all 0 is not sent. A wide beat whose keep bits are all 0 gives a single narrow beat from segment 0 with keep 0.
- R7: Splitting: outLast is high only on the last narrow beat that was sent, and only if the wide beat had inLast. outUser is high only on that beat, and only if the wide beat had both inLast and inUser.
- R8: Only the wide side stalls. When packing, inReady is low only while a finished wide word waits with outReady low. When splitting, outValid stays high from acceptance until the final segment transfers. inReady is high in the cycle the final segment transfers, so the next wide beat loads with no gap.
- R9: Synchronous reset discards any partly packed or held word. After reset outValid is 0 and inReady is 1, and packing restarts at segment 0.
- R10: With equal lane counts, all outputs follow the inputs in the same cycle and inReady follows outReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inData | input | IN_LANES*LANE_W | Input data, lane 0 in the low bits |
| inKeep | input | IN_LANES | Input lane valid mask |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Adapter can take an input beat |
| inLast | input | 1 | Input beat ends a frame |
| inUser | input | 1 | Input bad-frame flag, read with inLast |
| outData | output | OUT_LANES*LANE_W | Output data, lane 0 in the low bits |
| outKeep | output | OUT_LANES | Output lane valid mask |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Sink can take an output beat |
| outLast | output | 1 | Output beat ends a frame |
| outUser | output | 1 | Output bad-frame flag |

## Verification
A wrong fill index in packing mode shows at the ports within one ratio of narrow beats. The wide word then appears one or more beats early or late, or its segments arrive shifted or with stale lanes whose keep is set. A wrong read index in splitting mode shows at the next narrow transfer as a repeated, missing or reordered segment, or as an empty segment that was not skipped. A wrong hold or full flag shows in the same cycle as inReady that disagrees with the state the port history implies, or as the end-of-frame marker landing on the wrong narrow beat. The bench checks every cycle of the packing sequence and every narrow beat of the split sequences, so each such fault shows up at the first beat it affects.

// File: rtl/lwa_pkg.sv
package lwa_pkg;
  localparam int SEL_W = 8;

  typedef struct packed {
    logic             load;
    logic             fresh;
    logic [SEL_W-1:0] seg;
  } lwaStrobe_t;
endpackage

// File: rtl/lwa_ctrl.sv
module lwa_ctrl import lwa_pkg::*; #(
  parameter int IN_LANES  = 2,
  parameter int OUT_LANES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic inValid,
  input  logic inLast,
  output logic inReady,
  output logic outValid,
  input  logic outReady,
  input  logic [((IN_LANES > OUT_LANES) ? IN_LANES / OUT_LANES : OUT_LANES / IN_LANES)-1:0] inSegHas,
  input  logic [((IN_LANES > OUT_LANES) ? IN_LANES / OUT_LANES : OUT_LANES / IN_LANES)-1:0] holdSegHas,
  output lwaStrobe_t strobe,
  output logic finalSeg
);
  localparam int WIDE   = (IN_LANES > OUT_LANES) ? IN_LANES : OUT_LANES;
  localparam int NARROW = (IN_LANES > OUT_LANES) ? OUT_LANES : IN_LANES;
  localparam int RATIO  = WIDE / NARROW;

  if (IN_LANES < OUT_LANES) begin : g_pack
    logic [SEL_W-1:0] fillIdx;
    logic wordFull, accept, closeWord;
    logic unusedPack;
    assign unusedPack = ^{inSegHas, holdSegHas};

    always_comb begin
      outValid  = wordFull;
      inReady   = !wordFull || outReady;
      accept    = inValid && inReady;
      closeWord = accept && (inLast || fillIdx == SEL_W'(RATIO - 1));
      strobe    = '{load: accept, fresh: (fillIdx == '0), seg: fillIdx};
      finalSeg  = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        fillIdx  <= '0;
        wordFull <= 1'b0;
      end else begin
        wordFull <= (wordFull && !outReady) || closeWord;
        if (accept) fillIdx <= closeWord ? '0 : fillIdx + 1'b1;
      end
    end

    AST_PACK_LAST_CLOSES: assert property (@(posedge clk) disable iff (rst)
      (inValid && inReady && inLast) |=> outValid); // R3
  end else if (IN_LANES > OUT_LANES) begin : g_split
    logic [SEL_W-1:0] readIdx, firstIn, lastHold, nextHold;
    logic holding, wordDone, accept;
    logic unusedSplit;
    assign unusedSplit = inLast;

    always_comb begin
      firstIn = '0;
      for (int k = RATIO - 1; k >= 0; k--) if (inSegHas[k]) firstIn = SEL_W'(k);
      lastHold = '0;
      for (int k = 0; k < RATIO; k++) if (holdSegHas[k]) lastHold = SEL_W'(k);
      nextHold = readIdx;
      for (int k = RATIO - 1; k >= 0; k--)
        if (holdSegHas[k] && SEL_W'(k) > readIdx) nextHold = SEL_W'(k);
    end

    always_comb begin
      finalSeg = (readIdx == lastHold);
      outValid = holding;
      wordDone = holding && outReady && finalSeg;
      inReady  = !holding || wordDone;
      accept   = inValid && inReady;
      strobe   = '{load: accept, fresh: 1'b1, seg: readIdx};
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        holding <= 1'b0;
        readIdx <= '0;
      end else if (accept) begin
        holding <= 1'b1;
        readIdx <= firstIn;
      end else if (wordDone) begin
        holding <= 1'b0;
      end else if (holding && outReady) begin
        readIdx <= nextHold;
      end
    end

    AST_SPLIT_NO_GAP: assert property (@(posedge clk) disable iff (rst)
      (outValid && outReady && !inReady) |=> outValid); // R8
  end else begin : g_wire
    logic unusedWire;
    assign unusedWire = ^{clk, rst, inLast, inSegHas, holdSegHas};
    always_comb begin
      inReady  = outReady;
      outValid = inValid;
      strobe   = '0;
      finalSeg = 1'b1;
    end
  end
endmodule

// File: rtl/lwa_datapath.sv
module lwa_datapath import lwa_pkg::*; #(
  parameter int LANE_W    = 8,
  parameter int IN_LANES  = 2,
  parameter int OUT_LANES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic [IN_LANES*LANE_W-1:0] inData,
  input  logic [IN_LANES-1:0] inKeep,
  input  logic inLast,
  input  logic inUser,
  input  lwaStrobe_t strobe,
  input  logic finalSeg,
  output logic [OUT_LANES*LANE_W-1:0] outData,
  output logic [OUT_LANES-1:0] outKeep,
  output logic outLast,
  output logic outUser,
  output logic [((IN_LANES > OUT_LANES) ? IN_LANES / OUT_LANES : OUT_LANES / IN_LANES)-1:0] inSegHas,
  output logic [((IN_LANES > OUT_LANES) ? IN_LANES / OUT_LANES : OUT_LANES / IN_LANES)-1:0] holdSegHas
);
  localparam int WIDE     = (IN_LANES > OUT_LANES) ? IN_LANES : OUT_LANES;
  localparam int NARROW   = (IN_LANES > OUT_LANES) ? OUT_LANES : IN_LANES;
  localparam int RATIO    = WIDE / NARROW;
  localparam int SEG_BITS = NARROW * LANE_W;

  if (IN_LANES < OUT_LANES) begin : g_pack
    logic [OUT_LANES*LANE_W-1:0] wData;
    logic [OUT_LANES-1:0] wKeep;
    logic wLast, wUser;
    logic unusedPack;
    assign unusedPack = finalSeg;

    always_ff @(posedge clk) begin
      if (rst) begin
        wData <= '0;
        wKeep <= '0;
        wLast <= 1'b0;
        wUser <= 1'b0;
      end else if (strobe.load) begin
        for (int k = 0; k < RATIO; k++) begin
          if (strobe.seg == SEL_W'(k)) begin
            wData[k*SEG_BITS +: SEG_BITS] <= inData;
            wKeep[k*NARROW +: NARROW]     <= inKeep;
          end else if (strobe.fresh) begin
            wData[k*SEG_BITS +: SEG_BITS] <= '0;
            wKeep[k*NARROW +: NARROW]     <= '0;
          end
        end
        wLast <= inLast;
        wUser <= inUser && inLast;
      end
    end

    assign outData    = wData;
    assign outKeep    = wKeep;
    assign outLast    = wLast;
    assign outUser    = wUser;
    assign inSegHas   = '0;
    assign holdSegHas = '0;
  end else if (IN_LANES > OUT_LANES) begin : g_split
    logic [IN_LANES*LANE_W-1:0] hData;
    logic [IN_LANES-1:0] hKeep;
    logic hLast, hUser;
    logic unusedSplit;
    assign unusedSplit = strobe.fresh;

    always_ff @(posedge clk) begin
      if (rst) begin
        hData <= '0;
        hKeep <= '0;
        hLast <= 1'b0;
        hUser <= 1'b0;
      end else if (strobe.load) begin
        hData <= inData;
        hKeep <= inKeep;
        hLast <= inLast;
        hUser <= inUser && inLast;
      end
    end

    for (genvar k = 0; k < RATIO; k++) begin : g_seg
      assign inSegHas[k]   = |inKeep[k*NARROW +: NARROW];
      assign holdSegHas[k] = |hKeep[k*NARROW +: NARROW];
    end

    always_comb begin
      outData = hData[SEG_BITS-1:0];
      outKeep = hKeep[NARROW-1:0];
      for (int k = 1; k < RATIO; k++) begin
        if (strobe.seg == SEL_W'(k)) begin
          outData = hData[k*SEG_BITS +: SEG_BITS];
          outKeep = hKeep[k*NARROW +: NARROW];
        end
      end
    end

    assign outLast = hLast && finalSeg;
    assign outUser = hUser && finalSeg;
  end else begin : g_wire
    logic unusedWire;
    assign unusedWire = ^{clk, rst, strobe, finalSeg};
    assign outData    = inData;
    assign outKeep    = inKeep;
    assign outLast    = inLast;
    assign outUser    = inUser;
    assign inSegHas   = '0;
    assign holdSegHas = '0;
  end
endmodule

// File: rtl/lane_width_adapter.sv
module lane_width_adapter import lwa_pkg::*; #(
  parameter int LANE_W    = 8,
  parameter int IN_LANES  = 2,
  parameter int OUT_LANES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic [IN_LANES*LANE_W-1:0] inData,
  input  logic [IN_LANES-1:0] inKeep,
  input  logic inValid,
  output logic inReady,
  input  logic inLast,
  input  logic inUser,
  output logic [OUT_LANES*LANE_W-1:0] outData,
  output logic [OUT_LANES-1:0] outKeep,
  output logic outValid,
  input  logic outReady,
  output logic outLast,
  output logic outUser
);
  localparam int WIDE   = (IN_LANES > OUT_LANES) ? IN_LANES : OUT_LANES;
  localparam int NARROW = (IN_LANES > OUT_LANES) ? OUT_LANES : IN_LANES;
  localparam int RATIO  = WIDE / NARROW;

  logic [RATIO-1:0] inSegHas, holdSegHas;
  lwaStrobe_t strobe;
  logic finalSeg;

  lwa_ctrl #(.IN_LANES(IN_LANES), .OUT_LANES(OUT_LANES)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .inSegHas(inSegHas),
    .holdSegHas(holdSegHas), .strobe(strobe), .finalSeg(finalSeg)
  );

  lwa_datapath #(.LANE_W(LANE_W), .IN_LANES(IN_LANES), .OUT_LANES(OUT_LANES)) u_dp (
    .clk(clk), .rst(rst), .inData(inData), .inKeep(inKeep), .inLast(inLast),
    .inUser(inUser), .strobe(strobe), .finalSeg(finalSeg), .outData(outData),
    .outKeep(outKeep), .outLast(outLast), .outUser(outUser),
    .inSegHas(inSegHas), .holdSegHas(holdSegHas)
  );

  if (IN_LANES != OUT_LANES) begin : g_chk
    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
      (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outKeep)
                                   && $stable(outLast) && $stable(outUser))); // R1
    AST_USER_NEEDS_LAST: assert property (@(posedge clk) disable iff (rst)
      (outValid && outUser) |-> outLast); // R4
    AST_RST_EMPTY: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !outValid); // R9
  end
  if (IN_LANES > OUT_LANES) begin : g_chk_split
    AST_SPLIT_MID_KEEP: assert property (@(posedge clk) disable iff (rst)
      (outValid && outReady && !inReady) |-> (outKeep != '0)); // R6
  end
endmodule

// File: tb/test_lane_width_adapter.sv
`timescale 1ns/1ps
module test_lane_width_adapter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [15:0] uInData;  logic [1:0] uInKeep;  logic uInValid, uInReady, uInLast, uInUser;
  logic [47:0] uOutData; logic [5:0] uOutKeep; logic uOutValid, uOutReady, uOutLast, uOutUser;
  logic [47:0] dInData;  logic [5:0] dInKeep;  logic dInValid, dInReady, dInLast, dInUser;
  logic [15:0] dOutData; logic [1:0] dOutKeep; logic dOutValid, dOutReady, dOutLast, dOutUser;
  logic [31:0] eInData;  logic [3:0] eInKeep;  logic eInValid, eInReady, eInLast, eInUser;
  logic [31:0] eOutData; logic [3:0] eOutKeep; logic eOutValid, eOutReady, eOutLast, eOutUser;

  lane_width_adapter #(.LANE_W(8), .IN_LANES(2), .OUT_LANES(6)) i_lane_width_adapter (
    .clk(clk), .rst(rst), .inData(uInData), .inKeep(uInKeep), .inValid(uInValid),
    .inReady(uInReady), .inLast(uInLast), .inUser(uInUser), .outData(uOutData),
    .outKeep(uOutKeep), .outValid(uOutValid), .outReady(uOutReady),
    .outLast(uOutLast), .outUser(uOutUser));
  lane_width_adapter #(.LANE_W(8), .IN_LANES(6), .OUT_LANES(2)) i_lane_width_adapter_dn (
    .clk(clk), .rst(rst), .inData(dInData), .inKeep(dInKeep), .inValid(dInValid),
    .inReady(dInReady), .inLast(dInLast), .inUser(dInUser), .outData(dOutData),
    .outKeep(dOutKeep), .outValid(dOutValid), .outReady(dOutReady),
    .outLast(dOutLast), .outUser(dOutUser));
  lane_width_adapter #(.LANE_W(8), .IN_LANES(4), .OUT_LANES(4)) i_lane_width_adapter_eq (
    .clk(clk), .rst(rst), .inData(eInData), .inKeep(eInKeep), .inValid(eInValid),
    .inReady(eInReady), .inLast(eInLast), .inUser(eInUser), .outData(eOutData),
    .outKeep(eOutKeep), .outValid(eOutValid), .outReady(eOutReady),
    .outLast(eOutLast), .outUser(eOutUser));

  // {inData16, inKeep2, inLast, inUser, expValid, expData48, expKeep6, expLast, expUser}
  localparam logic [76:0] UP_TAB [0:9] = '{
    {16'h0201, 2'b11, 1'b0, 1'b0, 1'b0, 48'h0,            6'h00, 1'b0, 1'b0},
    {16'h0403, 2'b11, 1'b0, 1'b0, 1'b0, 48'h0,            6'h00, 1'b0, 1'b0},
    {16'h0605, 2'b11, 1'b0, 1'b0, 1'b1, 48'h060504030201, 6'h3f, 1'b0, 1'b0},
    {16'h0807, 2'b11, 1'b1, 1'b1, 1'b1, 48'h000000000807, 6'h03, 1'b1, 1'b1},
    {16'h0a09, 2'b11, 1'b0, 1'b0, 1'b0, 48'h0,            6'h00, 1'b0, 1'b0},
    {16'h0c0b, 2'b01, 1'b1, 1'b0, 1'b1, 48'h00000c0b0a09, 6'h07, 1'b1, 1'b0},
    {16'h0e0d, 2'b11, 1'b0, 1'b1, 1'b0, 48'h0,            6'h00, 1'b0, 1'b0},
    {16'h100f, 2'b11, 1'b0, 1'b0, 1'b0, 48'h0,            6'h00, 1'b0, 1'b0},
    {16'h1211, 2'b11, 1'b1, 1'b1, 1'b1, 48'h1211100f0e0d, 6'h3f, 1'b1, 1'b1},
    {16'h1413, 2'b01, 1'b1, 1'b0, 1'b1, 48'h000000001413, 6'h01, 1'b1, 1'b0}
  };

  int nChecks = 0;
  int nErr = 0;
  logic [76:0] vec;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic uSend(input logic [15:0] d, input logic [1:0] k, input logic l, input logic u);
    logic rdy;
    uInData = d; uInKeep = k; uInLast = l; uInUser = u; uInValid = 1'b1;
    do begin
      rdy = uInReady;
      @(posedge clk);
      if (!rdy) @(negedge clk);
    end while (!rdy);
    @(negedge clk);
    uInValid = 1'b0;
  endtask

  task automatic dSend(input logic [47:0] d, input logic [5:0] k, input logic l, input logic u);
    logic rdy;
    dInData = d; dInKeep = k; dInLast = l; dInUser = u; dInValid = 1'b1;
    do begin
      rdy = dInReady;
      @(posedge clk);
      if (!rdy) @(negedge clk);
    end while (!rdy);
    @(negedge clk);
    dInValid = 1'b0;
  endtask

  task automatic dBeat(input string req, input logic [15:0] d, input logic [1:0] k,
                       input logic l, input logic u);
    check(req, 64'({dOutValid, dOutData, dOutKeep, dOutLast, dOutUser}),
          64'({1'b1, d, k, l, u}));
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    uInData = '0; uInKeep = '0; uInValid = 1'b0; uInLast = 1'b0; uInUser = 1'b0; uOutReady = 1'b1;
    dInData = '0; dInKeep = '0; dInValid = 1'b0; dInLast = 1'b0; dInUser = 1'b0; dOutReady = 1'b1;
    eInData = '0; eInKeep = '0; eInValid = 1'b0; eInLast = 1'b0; eInUser = 1'b0; eOutReady = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    check("R9 reset pack", 64'({uOutValid, uInReady}), 64'(2'b01));
    check("R9 reset split", 64'({dOutValid, dInReady}), 64'(2'b01));

    // R2 R3 R4 table walk, one narrow beat per cycle, sink always ready
    for (int i = 0; i < 10; i++) begin
      vec = UP_TAB[i];
      check("R8 pack ready", 64'(uInReady), 64'(1));
      uInData = vec[76:61]; uInKeep = vec[60:59]; uInLast = vec[58]; uInUser = vec[57];
      uInValid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      if (vec[56])
        check("R2 R3 R4 packed word",
              64'({uOutValid, uOutData, uOutKeep, uOutLast, uOutUser}),
              64'({1'b1, vec[55:0]}));
      else
        check("R2 word not early", 64'(uOutValid), 64'(0));
    end
    uInValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 pack drained", 64'(uOutValid), 64'(0));

    // R1 R8 packing under backpressure
    uOutReady = 1'b0;
    uSend(16'h2221, 2'b11, 1'b0, 1'b0);
    uSend(16'h2423, 2'b11, 1'b0, 1'b0);
    uSend(16'h2625, 2'b11, 1'b0, 1'b0);
    uInData = 16'h2827; uInKeep = 2'b11; uInLast = 1'b1; uInUser = 1'b0; uInValid = 1'b1;
    check("R8 pack stall", 64'(uInReady), 64'(0));
    check("R2 full word", 64'({uOutValid, uOutData}), 64'({1'b1, 48'h262524232221}));
    @(posedge clk);
    @(negedge clk);
    check("R1 pack hold", 64'({uOutValid, uOutData, uOutKeep}),
          64'({1'b1, 48'h262524232221, 6'h3f}));
    uOutReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R3 early close", 64'({uOutValid, uOutData, uOutKeep, uOutLast}),
          64'({1'b1, 48'h000000002827, 6'h03, 1'b1}));
    uInValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 pack fired", 64'(uOutValid), 64'(0));

    // R9 reset mid-word
    uSend(16'h3231, 2'b11, 1'b0, 1'b0);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R9 mid-word reset", 64'({uOutValid, uInReady}), 64'(2'b01));
    uSend(16'h4241, 2'b11, 1'b0, 1'b0);
    uSend(16'h4443, 2'b11, 1'b0, 1'b0);
    check("R9 no stale fill", 64'(uOutValid), 64'(0));
    uSend(16'h4645, 2'b11, 1'b0, 1'b0);
    check("R9 fresh word", 64'({uOutValid, uOutData, uOutKeep}),
          64'({1'b1, 48'h464544434241, 6'h3f}));
    @(posedge clk);
    @(negedge clk);

    // R5 R7 full split
    dSend(48'h665544332211, 6'h3f, 1'b1, 1'b1);
    dBeat("R5 seg0", 16'h2211, 2'b11, 1'b0, 1'b0);
    dBeat("R5 seg1", 16'h4433, 2'b11, 1'b0, 1'b0);
    dBeat("R7 seg2 last", 16'h6655, 2'b11, 1'b1, 1'b1);
    check("R5 split drained", 64'(dOutValid), 64'(0));

    // R6 skip empty middle segment
    dSend(48'haabbccddeeff, 6'b110011, 1'b1, 1'b1);
    dBeat("R6 seg0", 16'heeff, 2'b11, 1'b0, 1'b0);
    dBeat("R6 seg2 after skip", 16'haabb, 2'b11, 1'b1, 1'b1);
    check("R6 skip drained", 64'(dOutValid), 64'(0));

    // R7 partial last beat, trailing empty segment skipped
    dSend(48'h000000778899, 6'b000111, 1'b1, 1'b0);
    dBeat("R7 partial seg0", 16'h8899, 2'b11, 1'b0, 1'b0);
    dBeat("R7 partial seg1", 16'h0077, 2'b01, 1'b1, 1'b0);
    check("R7 partial drained", 64'(dOutValid), 64'(0));

    // R7 flag without end of frame
    dSend(48'h363534333231, 6'h3f, 1'b0, 1'b1);
    dBeat("R7 no-last seg0", 16'h3231, 2'b11, 1'b0, 1'b0);
    dBeat("R7 no-last seg1", 16'h3433, 2'b11, 1'b0, 1'b0);
    dBeat("R7 no-last seg2", 16'h3635, 2'b11, 1'b0, 1'b0);

    // R1 R8 split under backpressure and back-to-back words
    dOutReady = 1'b0;
    dSend(48'h0c0b0a090807, 6'h3f, 1'b1, 1'b0);
    dInData = 48'h161514131211; dInKeep = 6'h3f; dInLast = 1'b0; dInUser = 1'b0; dInValid = 1'b1;
    check("R8 split stall", 64'(dInReady), 64'(0));
    @(posedge clk);
    @(negedge clk);
    check("R1 split hold", 64'({dOutValid, dOutData}), 64'({1'b1, 16'h0807}));
    dOutReady = 1'b1;
    check("R8 mid-word stall", 64'(dInReady), 64'(0));
    dBeat("R1 seg0", 16'h0807, 2'b11, 1'b0, 1'b0);
    dBeat("R5 seg1", 16'h0a09, 2'b11, 1'b0, 1'b0);
    check("R8 ready on final", 64'(dInReady), 64'(1));
    dBeat("R7 final", 16'h0c0b, 2'b11, 1'b1, 1'b0);
    dInValid = 1'b0;
    dBeat("R8 no gap", 16'h1211, 2'b11, 1'b0, 1'b0);
    dBeat("R5 word2 seg1", 16'h1413, 2'b11, 1'b0, 1'b0);
    dBeat("R5 word2 seg2", 16'h1615, 2'b11, 1'b0, 1'b0);
    check("R8 split idle", 64'(dOutValid), 64'(0));

    // R10 equal lane counts
    eInData = 32'hcafef00d; eInKeep = 4'b0111; eInLast = 1'b1; eInUser = 1'b1; eInValid = 1'b1;
    #1;
    check("R10 wire", 64'({eOutValid, eOutData, eOutKeep, eOutLast, eOutUser, eInReady}),
          64'({1'b1, 32'hcafef00d, 4'b0111, 1'b1, 1'b1, 1'b0}));
    eOutReady = 1'b1;
    #1;
    check("R10 ready", 64'(eInReady), 64'(1));

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule